// File: doc/BRIEF.md
# Double-Buffered Residual Block Scanner

This block performs the statistics pass that precedes variable-length coding of a macroblock's sixteen 4x4 luma residual blocks. For each block it walks the sixteen quantised coefficients from the highest frequency down to DC, one per clock. From that walk it derives the nonzero coefficient count, the number of trailing unit-magnitude coefficients, the number of zeros lying below the highest nonzero coefficient, and a list of level/run pairs. The results go into one of two result banks.

A downstream coder takes a finished bank through a valid/release handshake. While it works on one block, the scanner fills the other bank with the next one, so scanning and coding overlap. An 8x8 quadrant whose coded-block-pattern bit is clear is skipped entirely: none of its four blocks is read or offered to the coder.

Top module: `cavlc_scanner`

## Requirements
- R1: During a block scan the block reads one coefficient per clock at `coef_rd_addr = {block_index[3:0], raster[3:0]}` with `coef_rd_en` high. The raster positions are visited in reverse zig-zag order 15, 14, 11, 7, 10, 13, 12, 9, 6, 3, 2, 5, 8, 4, 1, 0 (the zig-zag list, scan index 0 to 15, being 0, 1, 4, 8, 5, 2, 3, 6, 9, 12, 13, 10, 7, 11, 14, 15). Each scanned block takes exactly 16 reads, and read data is used in the cycle it is addressed.
- R2: When both banks are free, `blk_valid` rises 17 clock cycles after the rising edge that samples `mb_start`: one cycle to claim a bank, then sixteen for the coefficients.
- R3: `blk_total` equals the number of nonzero coefficients in the block (0 to 16).
- R4: `blk_trail_ones` counts consecutive coefficients of value +1 or -1 at the start of the nonzero list in scan order from high frequency. It stops at the first other value and is capped at 3.
- R5: `blk_total_zeros` equals the number of zero coefficients at scan positions below the highest nonzero coefficient. It is 0 for an all-zero block.
- R6: Symbol entry j (0 to `blk_total`-1), selected by `sym_sel`, holds the j-th nonzero coefficient met in the reverse scan as `sym_level`. Its `sym_run` is the number of zeros between it and the next lower nonzero coefficient. For the last entry, `sym_run` is the number of zeros below it down to DC.
- R7: Results stay on the outputs, unchanged, while `blk_valid` is high until a one-cycle `blk_release` is sampled. The next finished block then appears from the other bank.
- R8: Scanning of the next block stalls, with `coef_rd_en` low, while both banks hold unreleased results.
- R9: Blocks are processed in index order 0 to 15, where index = 4 x quadrant + sub-block. The four blocks of quadrant q are skipped when `mb_cbp[q]` is 0. A zero `mb_cbp` starts nothing and `busy` stays low.
- R10: `mb_start` is ignored while `busy` is high. `blk_release` is ignored while `blk_valid` is low.
- R11: After reset, `busy`, `blk_valid` and `coef_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mb_start | input | 1 | One-cycle request to scan a macroblock |
| mb_cbp | input | 4 | Quadrant coded flags, sampled with `mb_start` |
| busy | output | 1 | Macroblock in progress |
| coef_rd_en | output | 1 | Coefficient read strobe |
| coef_rd_addr | output | 8 | Block index and raster position of the read |
| coef_rd_data | input | COEF_W | Signed coefficient for the current address |
| blk_valid | output | 1 | A finished block is offered to the coder |
| blk_release | input | 1 | Coder frees the offered bank |
| blk_index | output | 4 | Index of the offered block |
| blk_total | output | 5 | Nonzero coefficient count |
| blk_trail_ones | output | 2 | Trailing unit-magnitude count |
| blk_total_zeros | output | 4 | Zeros below the highest nonzero coefficient |
| sym_sel | input | 4 | Symbol entry to read |
| sym_level | output | COEF_W | Level of the selected entry |
| sym_run | output | 4 | Zero run of the selected entry |

## Verification
The properties assume that the coefficient memory answers in the same cycle as the address, that `mb_cbp` is meaningful whenever `mb_start` is high, and that `blk_release` arrives as a single-cycle pulse per offered block. The bench models the residue store as a combinational array indexed by `coef_rd_addr`. It drives `mb_start` and `blk_release` as one-cycle pulses on the falling edge, and it changes coefficient contents only while the scanner is idle. A coder model with a programmable hold time fills both banks, so the stall path is exercised.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SCAN = 2'd2
    } scan_st_e;

    // raster position of zig-zag scan index k
    function automatic logic [3:0] zz_raster(input logic [3:0] k);
        logic [3:0] r;
        case (k)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd4;
            4'd3:  r = 4'd8;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd2;
            4'd6:  r = 4'd3;
            4'd7:  r = 4'd6;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd12;
            4'd10: r = 4'd13;
            4'd11: r = 4'd10;
            4'd12: r = 4'd7;
            4'd13: r = 4'd11;
            4'd14: r = 4'd14;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

    // lowest coded quadrant at or above lo; MSB flags a hit
    function automatic logic [2:0] next_quad(input logic [3:0] cbp, input logic [2:0] lo);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 3; i >= 0; i--) begin
            if ((3'(i) >= lo) && cbp[i]) begin
                r = {1'b1, 2'(i)};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cvs_symbol_acc.sv
module cvs_symbol_acc #(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic                     last,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     lvl_we,
    output logic [3:0]               lvl_idx,
    output logic signed [COEF_W-1:0] lvl_val,
    output logic                     run_we,
    output logic [3:0]               run_idx,
    output logic [3:0]               run_val,
    output logic                     run0_we,
    output logic [4:0]               tot_nx,
    output logic [1:0]               t1_nx,
    output logic [3:0]               tz_nx
);

    typedef struct packed {
        logic [4:0] cnt;
        logic [1:0] t1;
        logic       t1_open;
        logic [3:0] tz;
        logic [3:0] zrun;
    } acc_t;

    acc_t s_q, s_d;
    logic nz, is_one;
    logic [4:0] cnt_m1;

    always_comb begin
        s_d     = s_q;
        nz      = (coef != '0);
        is_one  = (coef == {{(COEF_W-1){1'b0}}, 1'b1}) || (coef == {COEF_W{1'b1}});
        cnt_m1  = s_q.cnt - 5'd1;
        lvl_we  = 1'b0;
        lvl_idx = s_q.cnt[3:0];
        lvl_val = coef;
        run_we  = 1'b0;
        run_idx = cnt_m1[3:0];
        run_val = s_q.zrun;
        run0_we = 1'b0;
        if (clear) begin
            s_d         = '0;
            s_d.t1_open = 1'b1;
        end else if (step) begin
            if (nz) begin
                lvl_we   = 1'b1;
                s_d.cnt  = s_q.cnt + 5'd1;
                s_d.zrun = 4'd0;
                run_we   = (s_q.cnt != 5'd0);
                run0_we  = last;
                if (s_q.t1_open) begin
                    if (is_one && (s_q.t1 != 2'd3)) begin
                        s_d.t1 = s_q.t1 + 2'd1;
                    end else begin
                        s_d.t1_open = 1'b0;
                    end
                end
            end else if (s_q.cnt != 5'd0) begin
                s_d.zrun = s_q.zrun + 4'd1;
                s_d.tz   = s_q.tz + 4'd1;
                if (last) begin
                    run_we  = 1'b1;
                    run_val = s_q.zrun + 4'd1;
                end
            end
        end
        tot_nx = s_d.cnt;
        t1_nx  = s_d.t1;
        tz_nx  = s_d.tz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cvs_bank_store.sv
module cvs_bank_store #(
    parameter int COEF_W = 16,
    parameter int NBANK  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_bank,
    input  logic                     lvl_we,
    input  logic [3:0]               lvl_idx,
    input  logic signed [COEF_W-1:0] lvl_val,
    input  logic                     run_we,
    input  logic [3:0]               run_idx,
    input  logic [3:0]               run_val,
    input  logic                     run0_we,
    input  logic [3:0]               run0_idx,
    input  logic                     stat_we,
    input  logic [3:0]               stat_blk,
    input  logic [4:0]               stat_tot,
    input  logic [1:0]               stat_t1,
    input  logic [3:0]               stat_tz,
    input  logic                     rd_bank,
    input  logic [3:0]               rd_entry,
    output logic signed [COEF_W-1:0] rd_level,
    output logic [3:0]               rd_run,
    output logic [3:0]               rd_blk,
    output logic [4:0]               rd_tot,
    output logic [1:0]               rd_t1,
    output logic [3:0]               rd_tz
);

    localparam int ENTRIES = 16;

    typedef struct packed {
        logic [ENTRIES-1:0][COEF_W-1:0] lvl;
        logic [ENTRIES-1:0][3:0]        run;
        logic [3:0]                     blk;
        logic [4:0]                     tot;
        logic [1:0]                     t1;
        logic [3:0]                     tz;
    } bank_t;

    bank_t [NBANK-1:0] b_q, b_d;

    always_comb begin
        b_d = b_q;
        for (int k = 0; k < NBANK; k++) begin
            if (wr_bank == 1'(k)) begin
                if (lvl_we)  b_d[k].lvl[lvl_idx]  = lvl_val;
                if (run_we)  b_d[k].run[run_idx]  = run_val;
                if (run0_we) b_d[k].run[run0_idx] = 4'd0;
                if (stat_we) begin
                    b_d[k].blk = stat_blk;
                    b_d[k].tot = stat_tot;
                    b_d[k].t1  = stat_t1;
                    b_d[k].tz  = stat_tz;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_level = b_q[rd_bank].lvl[rd_entry];
    assign rd_run   = b_q[rd_bank].run[rd_entry];
    assign rd_blk   = b_q[rd_bank].blk;
    assign rd_tot   = b_q[rd_bank].tot;
    assign rd_t1    = b_q[rd_bank].t1;
    assign rd_tz    = b_q[rd_bank].tz;

endmodule

// File: rtl/cavlc_scanner.sv
module cavlc_scanner
    import cvs_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mb_start,
    input  logic [3:0]               mb_cbp,
    output logic                     busy,
    output logic                     coef_rd_en,
    output logic [7:0]               coef_rd_addr,
    input  logic signed [COEF_W-1:0] coef_rd_data,
    output logic                     blk_valid,
    input  logic                     blk_release,
    output logic [3:0]               blk_index,
    output logic [4:0]               blk_total,
    output logic [1:0]               blk_trail_ones,
    output logic [3:0]               blk_total_zeros,
    input  logic [3:0]               sym_sel,
    output logic signed [COEF_W-1:0] sym_level,
    output logic [3:0]               sym_run
);

    typedef struct packed {
        scan_st_e   st;
        logic [3:0] blk;
        logic [3:0] pos;
        logic [3:0] cbp;
        logic       wr_bank;
        logic       rd_bank;
        logic [1:0] full;
    } ctl_t;

    ctl_t s_q, s_d;

    logic       acc_clear, acc_step, acc_last, stat_we;
    logic       lvl_we, run_we, run0_we;
    logic [3:0] lvl_idx, run_idx, run_val, tz_nx;
    logic [4:0] tot_nx;
    logic [1:0] t1_nx;
    logic signed [COEF_W-1:0] lvl_val;
    logic [2:0] nq, fq;

    always_comb begin
        s_d       = s_q;
        acc_clear = 1'b0;
        acc_step  = 1'b0;
        acc_last  = 1'b0;
        stat_we   = 1'b0;
        fq        = next_quad(mb_cbp, 3'd0);
        nq        = next_quad(s_q.cbp, {1'b0, s_q.blk[3:2]} + 3'd1);

        if (blk_release && s_q.full[s_q.rd_bank]) begin
            s_d.full[s_q.rd_bank] = 1'b0;
            s_d.rd_bank           = ~s_q.rd_bank;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (mb_start && fq[2]) begin
                    s_d.cbp = mb_cbp;
                    s_d.blk = {fq[1:0], 2'b00};
                    s_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!s_q.full[s_q.wr_bank]) begin
                    acc_clear = 1'b1;
                    s_d.pos   = 4'd15;
                    s_d.st    = ST_SCAN;
                end
            end
            ST_SCAN: begin
                acc_step = 1'b1;
                acc_last = (s_q.pos == 4'd0);
                s_d.pos  = s_q.pos - 4'd1;
                if (acc_last) begin
                    stat_we               = 1'b1;
                    s_d.full[s_q.wr_bank] = 1'b1;
                    s_d.wr_bank           = ~s_q.wr_bank;
                    if (s_q.blk[1:0] != 2'd3) begin
                        s_d.blk = s_q.blk + 4'd1;
                        s_d.st  = ST_WAIT;
                    end else if (nq[2]) begin
                        s_d.blk = {nq[1:0], 2'b00};
                        s_d.st  = ST_WAIT;
                    end else begin
                        s_d.st  = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = (s_q.st != ST_IDLE);
    assign coef_rd_en   = (s_q.st == ST_SCAN);
    assign coef_rd_addr = {s_q.blk, zz_raster(s_q.pos)};
    assign blk_valid    = s_q.full[s_q.rd_bank];

    cvs_symbol_acc #(.COEF_W(COEF_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .step    (acc_step),
        .last    (acc_last),
        .coef    (coef_rd_data),
        .lvl_we  (lvl_we),
        .lvl_idx (lvl_idx),
        .lvl_val (lvl_val),
        .run_we  (run_we),
        .run_idx (run_idx),
        .run_val (run_val),
        .run0_we (run0_we),
        .tot_nx  (tot_nx),
        .t1_nx   (t1_nx),
        .tz_nx   (tz_nx)
    );

    cvs_bank_store #(.COEF_W(COEF_W), .NBANK(2)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bank  (s_q.wr_bank),
        .lvl_we   (lvl_we),
        .lvl_idx  (lvl_idx),
        .lvl_val  (lvl_val),
        .run_we   (run_we),
        .run_idx  (run_idx),
        .run_val  (run_val),
        .run0_we  (run0_we),
        .run0_idx (lvl_idx),
        .stat_we  (stat_we),
        .stat_blk (s_q.blk),
        .stat_tot (tot_nx),
        .stat_t1  (t1_nx),
        .stat_tz  (tz_nx),
        .rd_bank  (s_q.rd_bank),
        .rd_entry (sym_sel),
        .rd_level (sym_level),
        .rd_run   (sym_run),
        .rd_blk   (blk_index),
        .rd_tot   (blk_total),
        .rd_t1    (blk_trail_ones),
        .rd_tz    (blk_total_zeros)
    );

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       coef_rd_en,
    input logic [7:0] coef_rd_addr,
    input logic       blk_valid,
    input logic       blk_release,
    input logic [3:0] blk_index,
    input logic [4:0] blk_total,
    input logic [1:0] blk_trail_ones,
    input logic [3:0] blk_total_zeros,
    input logic [3:0] cbp_q,
    input logic [1:0] full_q,
    input logic       wr_bank_q
);

    AST_T1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> ({3'd0, blk_trail_ones} <= blk_total)); // R4

    AST_ZERO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (({1'b0, blk_total_zeros} + blk_total) <= 5'd16)); // R5

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_release) |=> (blk_valid && $stable(blk_index) && $stable(blk_total))); // R7

    AST_SCAN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd_en && (coef_rd_addr[3:0] != 4'd0)) |=> (coef_rd_en && $stable(coef_rd_addr[7:4]))); // R1

    AST_SKIP_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_en |-> cbp_q[coef_rd_addr[7:6]]); // R9

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_en |-> !full_q[wr_bank_q]); // R8

endmodule

bind cavlc_scanner cvs_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .coef_rd_en      (coef_rd_en),
    .coef_rd_addr    (coef_rd_addr),
    .blk_valid       (blk_valid),
    .blk_release     (blk_release),
    .blk_index       (blk_index),
    .blk_total       (blk_total),
    .blk_trail_ones  (blk_trail_ones),
    .blk_total_zeros (blk_total_zeros),
    .cbp_q           (s_q.cbp),
    .full_q          (s_q.full),
    .wr_bank_q       (s_q.wr_bank)
);

// File: tb/cavlc_scanner_bench.sv
module cavlc_scanner_bench;

    localparam int COEF_W = 16;
    // {cbp[15:12], pattern[11:8], coder hold[7:0]}
    localparam logic [15:0] VEC [6] = '{16'hF100, 16'hF500, 16'h5200,
                                        16'hA300, 16'h8400, 16'h6000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                     mb_start = 1'b0;
    logic [3:0]               mb_cbp = 4'd0;
    logic                     busy, coef_rd_en, blk_valid;
    logic [7:0]               coef_rd_addr;
    logic signed [COEF_W-1:0] coef_rd_data;
    logic                     blk_release = 1'b0;
    logic [3:0]               blk_index, blk_total_zeros, sym_run;
    logic [4:0]               blk_total;
    logic [1:0]               blk_trail_ones;
    logic [3:0]               sym_sel = 4'd0;
    logic signed [COEF_W-1:0] sym_level;

    logic signed [COEF_W-1:0] mem [256];
    assign coef_rd_data = mem[coef_rd_addr];

    cavlc_scanner #(.COEF_W(COEF_W)) u_cavlc_scanner (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .mb_cbp(mb_cbp), .busy(busy),
        .coef_rd_en(coef_rd_en), .coef_rd_addr(coef_rd_addr), .coef_rd_data(coef_rd_data),
        .blk_valid(blk_valid), .blk_release(blk_release), .blk_index(blk_index),
        .blk_total(blk_total), .blk_trail_ones(blk_trail_ones),
        .blk_total_zeros(blk_total_zeros), .sym_sel(sym_sel), .sym_level(sym_level),
        .sym_run(sym_run));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int zz(input int k);
        int t [16] = '{0, 1, 4, 8, 5, 2, 3, 6, 9, 12, 13, 10, 7, 11, 14, 15};
        return t[k];
    endfunction

    function automatic int gen(input int pat, input int b, input int p);
        int h;
        case (pat)
            1: return 1;
            2: return (((b * 7 + p * 3) % 5) == 0) ? ((p % 2) ? -1 : 2) : 0;
            3: return (p % 3 == 0) ? (p - 7 + b) : ((p % 4 == 1) ? 1 : 0);
            4: return (p == 0) ? 5 : 0;
            5: begin
                h = (b * 29 + p * 17 + 3) % 11;
                return (h % 3 == 0) ? 0 : h - 5;
            end
            default: return 0;
        endcase
    endfunction

    // read-order monitor (R1)
    int mon_list [16];
    int mon_n = 0;
    int mon_i = 0;
    always @(negedge clk) begin
        if (rst_n && coef_rd_en) begin
            int e;
            e = (mon_i < mon_n * 16) ? mon_list[mon_i / 16] * 16 + zz(15 - (mon_i % 16)) : -1;
            check(int'(coef_rd_addr) == e, "R1 read address", int'(coef_rd_addr), e);
            mon_i++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    int exp_lvl [16];
    int exp_run [16];
    int exp_tot, exp_t1, exp_tz;

    task automatic ref_block(input int b);
        int pos [16];
        int n;
        bit open;
        n = 0;
        for (int k = 15; k >= 0; k--) begin
            int v;
            v = int'(mem[b * 16 + zz(k)]);
            if (v != 0) begin
                pos[n] = k;
                exp_lvl[n] = v;
                n++;
            end
        end
        exp_tot = n;
        exp_tz = (n > 0) ? pos[0] + 1 - n : 0;
        for (int j = 0; j < n; j++) begin
            exp_run[j] = (j == n - 1) ? pos[j] : pos[j] - pos[j + 1] - 1;
        end
        exp_t1 = 0;
        open = 1'b1;
        for (int j = 0; j < n && j < 3; j++) begin
            if (open && (exp_lvl[j] == 1 || exp_lvl[j] == -1)) exp_t1++;
            else open = 1'b0;
        end
    endtask

    task automatic run_mb(input logic [3:0] cbp, input int pat, input int hold,
                          input bit extra, input bit chk_lat);
        int w;
        for (int b = 0; b < 16; b++)
            for (int p = 0; p < 16; p++)
                mem[b * 16 + p] = COEF_W'(gen(pat, b, p));
        mon_n = 0;
        mon_i = 0;
        for (int q = 0; q < 4; q++)
            if (cbp[q])
                for (int s = 0; s < 4; s++) begin
                    mon_list[mon_n] = q * 4 + s;
                    mon_n++;
                end
        @(negedge clk);
        mb_cbp = cbp;
        mb_start = 1'b1;
        @(negedge clk);
        mb_start = 1'b0;
        for (int k = 0; k < mon_n; k++) begin
            w = 1;
            while (!blk_valid && w < 400) begin
                @(negedge clk);
                w++;
            end
            if (!blk_valid) begin
                check(1'b0, "R7 block never offered", 0, 1);
                return;
            end
            if (k == 0 && chk_lat) check(w == 18, "R2 first-block latency", w, 18);
            if (k == 0 && extra) begin
                mb_cbp = ~cbp;
                mb_start = 1'b1;
                @(negedge clk);
                mb_start = 1'b0;
            end
            if (k == 0 && hold > 0) begin
                repeat (hold) @(negedge clk);
                check(!coef_rd_en && busy, "R8 stall with both banks full", int'(coef_rd_en), 0);
                check(blk_index == 4'(mon_list[0]), "R7 offered block held", int'(blk_index), mon_list[0]);
            end
            ref_block(mon_list[k]);
            check(int'(blk_index) == mon_list[k], "R9 block order", int'(blk_index), mon_list[k]);
            check(int'(blk_total) == exp_tot, "R3 total coefficients", int'(blk_total), exp_tot);
            check(int'(blk_trail_ones) == exp_t1, "R4 trailing ones", int'(blk_trail_ones), exp_t1);
            check(int'(blk_total_zeros) == exp_tz, "R5 total zeros", int'(blk_total_zeros), exp_tz);
            for (int j = 0; j < exp_tot; j++) begin
                sym_sel = 4'(j);
                #2;
                check(int'(sym_level) == exp_lvl[j], "R6 symbol level", int'(sym_level), exp_lvl[j]);
                check(int'(sym_run) == exp_run[j], "R6 symbol run", int'(sym_run), exp_run[j]);
                @(negedge clk);
            end
            blk_release = 1'b1;
            @(negedge clk);
            blk_release = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(!busy && !blk_valid, extra ? "R10 extra start ignored" : "R9 no extra blocks",
              int'(busy) + int'(blk_valid), 0);
        check(mon_i == mon_n * 16, "R1 read count", mon_i, mon_n * 16);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy, "R11 busy after reset", int'(busy), 0);
        check(!blk_valid, "R11 valid after reset", int'(blk_valid), 0);
        check(!coef_rd_en, "R11 read strobe after reset", int'(coef_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++)
            run_mb(VEC[v][15:12], int'(VEC[v][11:8]), int'(VEC[v][7:0]), 1'b0, 1'b0);

        // R2 latency from idle with both banks free
        run_mb(4'h1, 5, 0, 1'b0, 1'b1);
        // R8 coder holds first bank long enough for the second to fill
        run_mb(4'hF, 3, 45, 1'b0, 1'b0);
        // R10 start pulse during a busy macroblock
        run_mb(4'h3, 2, 0, 1'b1, 1'b0);
        // R10 release with nothing offered
        blk_release = 1'b1;
        @(negedge clk);
        blk_release = 1'b0;
        @(negedge clk);
        check(!blk_valid, "R10 stray release", int'(blk_valid), 0);
        run_mb(4'h4, 4, 0, 1'b0, 1'b0);
        // R9 zero pattern starts nothing
        mb_cbp = 4'h0;
        mb_start = 1'b1;
        @(negedge clk);
        mb_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!busy && !coef_rd_en, "R9 zero pattern idle", int'(busy), 0);
        end
        report();
    end

endmodule